// File: doc/BRIEF.md
# Serial Register Port with Status Streaming

This block is a four-wire serial slave that lets a host controller read and write a bank of 8-bit registers. The serial pins are sampled by the system clock, which has to run at least eight times the serial clock rate. Each command is two bytes. The first byte holds a direction flag in its top bit and a 7-bit register address in the rest. The second byte carries the data, either from the host or back to it. Commands reach the register bank through a simple strobe interface with separate write and read sides. Read data must be returned combinationally in the same system clock cycle.

A read of one special address starts streaming mode. In the cycles right after the final address bit, the port reads a run of consecutive status registers into a snapshot buffer. It then shifts those bytes out back to back without any further addressing. Once streaming has started, the port accepts no new commands until chip select goes high again. Driving chip select high at any time abandons the current command and returns the port to its idle state. The data output is only driven while chip select is low, and this is shown on a separate enable pin.

Top module: `serreg_slave`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_miso`, `reg_wr_stb` and `reg_rd_stb` are all 0.
- R2: While the synchronized chip select is high, `spi_miso_oe` is 0 and no strobe is issued, whatever SCLK and MOSI do.
- R3: A command whose first byte has bit 7 = 1 is a write, with address = bits 6..0. After the 16th SCLK rising edge, with chip select still low, `reg_wr_stb` pulses for exactly one cycle. At that point `reg_wr_addr` holds the address and `reg_wr_data` holds the second byte. Bits are taken MSB first on SCLK rising edges.
- R4: A command whose first byte has bit 7 = 0 is a read. `reg_rd_stb` pulses for one cycle with that address after the 8th rising edge. The returned byte is shifted out MSB first, and MISO changes only after SCLK falling edges, so that the host samples bit 7 at rising edge 9 and bit 0 at rising edge 16.
- R5: If chip select goes high partway through a command, the command is dropped with no strobe. The next frame starts again at address bit 7.
- R6: Several commands can follow one another inside a single chip-select-low frame. Each new command starts at the rising edge after the previous 16th edge.
- R7: A read of address 0x42 causes seven one-cycle read strobes on consecutive clock cycles, to addresses 0x02 through 0x08 in rising order, right after the last address bit. The seven captured bytes are then streamed out in that order.
- R8: During streaming, every byte after the seventh is 0x00.
- R9: Once streaming has begun, further SCLK traffic produces no strobes, even if it encodes another streaming read. Normal commands work again after chip select has been high.
- R10: `spi_miso_oe` is 1 while the synchronized chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the data output pad |
| reg_wr_addr | output | 7 | Write address to register bank |
| reg_wr_data | output | 8 | Write data to register bank |
| reg_wr_stb | output | 1 | One-cycle write strobe |
| reg_rd_addr | output | 7 | Read address to register bank |
| reg_rd_stb | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data from register bank, same cycle |

## Verification
Each pin passes through two synchronizer stages and then one edge-detect comparison. As a result, a serial-clock edge reaches the logic two system clocks after it occurs. A write strobe follows about three clocks after the 16th rising edge, and a MISO change follows about three clocks after a falling edge. The streaming reads start one cycle after the address strobe cycle and run for seven consecutive cycles. The bench holds each serial-clock phase for eight system clocks, which is longer than any of these latencies. It samples MISO just before it raises SCLK, and it checks strobe counts, addresses and data only after the phase that produced them has ended, so every result is already settled when it is read. Strobes are logged on every clock edge, so a strobe that is missing or extra shows up as a wrong count, not as a race.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

   typedef enum logic {
      PORT_CMD    = 1'b0,
      PORT_STREAM = 1'b1
   } port_mode_e;

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/serreg_snap.sv
module serreg_snap #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 7,
   parameter int BURST_LEN  = 7,
   parameter int BURST_BASE = 2,
   localparam int IDX_W     = $clog2(BURST_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              start,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cap_on,
   output logic              cap_first,
   output logic [ADDR_W-1:0] cap_addr,
   input  logic [IDX_W-1:0]  sel,
   output logic [DATA_W-1:0] sel_byte
);

   logic [IDX_W-1:0]  idx_q;
   logic              on_q;
   logic [DATA_W-1:0] snap_q [BURST_LEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         idx_q <= '0;
      end else if (clear) begin
         on_q  <= 1'b0;
         idx_q <= '0;
      end else if (start) begin
         on_q  <= 1'b1;
         idx_q <= '0;
      end else if (on_q) begin
         if (idx_q == IDX_W'(BURST_LEN - 1)) on_q <= 1'b0;
         idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < BURST_LEN; k++) snap_q[k] <= '0;
      end else begin
         for (int k = 0; k < BURST_LEN; k++)
            if (on_q && idx_q == IDX_W'(k)) snap_q[k] <= rd_data;
      end
   end

   always_comb begin
      sel_byte = '0;
      for (int k = 0; k < BURST_LEN; k++)
         if (sel == IDX_W'(k)) sel_byte = snap_q[k];
   end

   assign cap_on    = on_q;
   assign cap_first = on_q && (idx_q == '0);
   assign cap_addr  = ADDR_W'(BURST_BASE) + ADDR_W'(idx_q);

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
   import serreg_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BURST_ADDR  = 'h42,
   parameter int BURST_BASE  = 'h02,
   parameter int BURST_LEN   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_wr_addr,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_wr_stb,
   output logic [ADDR_W-1:0] reg_rd_addr,
   output logic              reg_rd_stb,
   input  logic [DATA_W-1:0] reg_rd_data
);

   localparam int CNT_W  = $clog2(2 * DATA_W);
   localparam int BYTE_W = $clog2(DATA_W);
   localparam int IDX_W  = $clog2(BURST_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 2 or more");
   end
   if (ADDR_W + 1 != DATA_W) begin : g_bad_width
      $error("address plus direction bit must fill one data byte");
   end
   if ((1 << BYTE_W) != DATA_W) begin : g_bad_pow2
      $error("DATA_W must be a power of two");
   end
   if (BURST_BASE + BURST_LEN > (1 << ADDR_W)) begin : g_bad_burst
      $error("streamed register run leaves the address space");
   end

   // input synchronizers: {cs_n, sclk, mosi}
   logic cs_n_s, sclk_s, mosi_s;
   serreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     ({cs_n_s, sclk_s, mosi_s})
   );

   logic sclk_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b1;
      else        sclk_q <= sclk_s;
   end

   logic sclk_rise, sclk_fall;
   assign sclk_rise = !cs_n_s &&  sclk_s && !sclk_q;
   assign sclk_fall = !cs_n_s && !sclk_s &&  sclk_q;

   port_mode_e        mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-2:0] sh_q;
   logic              dir_wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] tx_q;
   logic              miso_q;
   logic [IDX_W-1:0]  byte_idx_q;
   logic              wr_stb_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;

   logic [DATA_W-1:0] byte_in;
   logic [ADDR_W-1:0] hdr_addr;
   logic              hdr_read, addr_done, data_done, burst_go, single_rd;
   logic              stream_adv, in_stream;

   assign in_stream  = (mode_q == PORT_STREAM);
   assign byte_in    = {sh_q, mosi_s};
   assign hdr_addr   = byte_in[ADDR_W-1:0];
   assign hdr_read   = !byte_in[DATA_W-1];
   assign addr_done  = sclk_rise && !in_stream && (cnt_q == CNT_W'(DATA_W - 1));
   assign data_done  = sclk_rise && !in_stream && (cnt_q == CNT_W'(2 * DATA_W - 1));
   assign burst_go   = addr_done && hdr_read && (hdr_addr == ADDR_W'(BURST_ADDR));
   assign single_rd  = addr_done && hdr_read && !burst_go;
   assign stream_adv = sclk_rise && in_stream && (&cnt_q[BYTE_W-1:0]);

   // snapshot of streamed status registers
   logic              cap_on, cap_first;
   logic [ADDR_W-1:0] cap_addr;
   logic [IDX_W-1:0]  nxt_idx;
   logic [DATA_W-1:0] nxt_byte;

   assign nxt_idx = (byte_idx_q == IDX_W'(BURST_LEN)) ? byte_idx_q : byte_idx_q + 1'b1;

   serreg_snap #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .BURST_LEN  (BURST_LEN),
      .BURST_BASE (BURST_BASE)
   ) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cs_n_s),
      .start     (burst_go),
      .rd_data   (reg_rd_data),
      .cap_on    (cap_on),
      .cap_first (cap_first),
      .cap_addr  (cap_addr),
      .sel       (nxt_idx),
      .sel_byte  (nxt_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= PORT_CMD;
         cnt_q      <= '0;
         sh_q       <= '0;
         dir_wr_q   <= 1'b0;
         addr_q     <= '0;
         tx_q       <= '0;
         miso_q     <= 1'b0;
         byte_idx_q <= '0;
         wr_stb_q   <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
      end else if (cs_n_s) begin
         mode_q     <= PORT_CMD;
         cnt_q      <= '0;
         sh_q       <= '0;
         dir_wr_q   <= 1'b0;
         tx_q       <= '0;
         miso_q     <= 1'b0;
         byte_idx_q <= '0;
         wr_stb_q   <= 1'b0;
      end else begin
         wr_stb_q <= 1'b0;
         if (sclk_rise) begin
            sh_q  <= byte_in[DATA_W-2:0];
            cnt_q <= cnt_q + 1'b1;
         end
         if (addr_done) begin
            dir_wr_q <= byte_in[DATA_W-1];
            addr_q   <= hdr_addr;
            if (burst_go)      mode_q <= PORT_STREAM;
            else if (hdr_read) tx_q   <= reg_rd_data;
         end
         if (data_done && dir_wr_q) begin
            wr_stb_q  <= 1'b1;
            wr_addr_q <= addr_q;
            wr_data_q <= byte_in;
         end
         if (cap_first) tx_q <= reg_rd_data;
         if (stream_adv) begin
            tx_q       <= nxt_byte;
            byte_idx_q <= nxt_idx;
         end
         if (sclk_fall) begin
            miso_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign spi_miso    = miso_q;
   assign spi_miso_oe = !cs_n_s;
   assign reg_wr_stb  = wr_stb_q;
   assign reg_wr_addr = wr_addr_q;
   assign reg_wr_data = wr_data_q;
   assign reg_rd_stb  = single_rd || cap_on;
   assign reg_rd_addr = cap_on ? cap_addr : hdr_addr;

endmodule

// File: rtl/serreg_slave_chk.sv
module serreg_slave_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miso,
   input logic              miso_oe,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              sclk_fall,
   input logic              in_stream
);

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> (!wr_stb && !rd_stb)); // R2

   AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R3

   AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb)); // R4

   AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && !$past(sclk_fall)) |-> $stable(miso)); // R4

   AST_STREAM_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && $past(rd_stb)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1))); // R7

   AST_STREAM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_stream |-> !wr_stb); // R9

endmodule

bind serreg_slave serreg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .miso      (spi_miso),
   .miso_oe   (spi_miso_oe),
   .wr_stb    (reg_wr_stb),
   .rd_stb    (reg_rd_stb),
   .rd_addr   (reg_rd_addr),
   .sclk_fall (sclk_fall),
   .in_stream (in_stream)
);

// File: tb/sim_serreg_slave.sv
module sim_serreg_slave;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe, wr_stb, rd_stb;
   logic [6:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   int wr_count = 0;
   int rd_count = 0;
   logic [6:0] rd_log [64];
   logic [6:0] last_wa = '0;
   logic [7:0] last_wd = '0;

   always #4 clk = ~clk;

   function automatic logic [7:0] regval(input logic [6:0] a);
      return 8'(a) * 8'd37 + 8'd11;
   endfunction

   assign rd_data = regval(rd_addr);

   serreg_slave u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (cs_n),
      .spi_sclk    (sclk),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .reg_wr_addr (wr_addr),
      .reg_wr_data (wr_data),
      .reg_wr_stb  (wr_stb),
      .reg_rd_addr (rd_addr),
      .reg_rd_stb  (rd_stb),
      .reg_rd_data (rd_data)
   );

   always @(posedge clk) begin
      if (wr_stb) begin
         wr_count <= wr_count + 1;
         last_wa  <= wr_addr;
         last_wd  <= wr_data;
      end
      if (rd_stb) begin
         if (rd_count < 64) rd_log[rd_count] <= rd_addr;
         rd_count <= rd_count + 1;
      end
   end

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbits(input logic [15:0] v, input int nbits, output logic [15:0] rx);
      rx = '0;
      for (int i = nbits - 1; i >= 0; i--) begin
         sclk = 1'b0;
         mosi = v[i];
         wclk(HALF);
         rx[i] = miso;
         sclk = 1'b1;
         wclk(HALF);
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      logic [15:0] r;
      xbits({8'h00, tx}, 8, r);
      rx = r[7:0];
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      wclk(HALF);
   endtask

   task automatic cs_hi();
      cs_n = 1'b1;
      wclk(2 * HALF);
   endtask

   task automatic t_reset();
      check_eq("R1 miso_oe", miso_oe, 0);
      check_eq("R1 miso", miso, 0);
      check_eq("R1 wr strobes", wr_count, 0);
      check_eq("R1 rd strobes", rd_count, 0);
   endtask

   task automatic t_cs_high_ignored();
      logic [7:0] r;
      int w0 = wr_count;
      int r0 = rd_count;
      xbyte(8'h93, r);
      xbyte(8'h5A, r);
      xbyte(8'h07, r);
      wclk(4);
      check_eq("R2 no write with cs high", wr_count, w0);
      check_eq("R2 no read with cs high", rd_count, r0);
      check_eq("R2 miso_oe low", miso_oe, 0);
   endtask

   task automatic t_write();
      logic [7:0] r;
      int w0 = wr_count;
      int r0 = rd_count;
      cs_lo();
      check_eq("R10 miso_oe with cs low", miso_oe, 1);
      xbyte(8'h95, r);
      xbyte(8'h3C, r);
      wclk(4);
      check_eq("R3 one write strobe", wr_count, w0 + 1);
      check_eq("R3 write address", last_wa, 7'h15);
      check_eq("R3 write data", last_wd, 8'h3C);
      check_eq("R3 no read strobe", rd_count, r0);
      cs_hi();
      check_eq("R2 miso_oe after cs high", miso_oe, 0);
   endtask

   task automatic t_read();
      logic [7:0] r;
      int r0 = rd_count;
      cs_lo();
      xbyte(8'h09, r);
      xbyte(8'h00, r);
      cs_hi();
      check_eq("R4 read data", r, regval(7'h09));
      check_eq("R4 one read strobe", rd_count, r0 + 1);
      check_eq("R4 read address", rd_log[r0], 7'h09);
   endtask

   task automatic t_back_to_back();
      logic [7:0] r;
      int w0 = wr_count;
      int r0 = rd_count;
      cs_lo();
      xbyte(8'hA0, r);
      xbyte(8'hA7, r);
      xbyte(8'h11, r);
      xbyte(8'hFF, r);
      cs_hi();
      check_eq("R6 first write", wr_count, w0 + 1);
      check_eq("R6 write addr", last_wa, 7'h20);
      check_eq("R6 write data", last_wd, 8'hA7);
      check_eq("R6 second read addr", rd_log[r0], 7'h11);
      check_eq("R6 second read data", r, regval(7'h11));
   endtask

   task automatic t_abort();
      logic [15:0] r16;
      logic [7:0]  r;
      int w0 = wr_count;
      cs_lo();
      xbits(16'h8AFF, 12, r16);
      cs_hi();
      check_eq("R5 aborted write dropped", wr_count, w0);
      cs_lo();
      xbyte(8'h85, r);
      xbyte(8'h66, r);
      cs_hi();
      check_eq("R5 fresh write count", wr_count, w0 + 1);
      check_eq("R5 fresh write addr", last_wa, 7'h05);
      check_eq("R5 fresh write data", last_wd, 8'h66);
   endtask

   task automatic t_stream();
      logic [7:0] r;
      logic [7:0] got [9];
      int w0 = wr_count;
      int r0 = rd_count;
      cs_lo();
      xbyte(8'h42, r);
      for (int k = 0; k < 9; k++) xbyte(8'h00, got[k]);
      check_eq("R7 seven capture reads", rd_count, r0 + 7);
      for (int k = 0; k < 7; k++) begin
         check_eq("R7 capture address order", rd_log[r0 + k], 7'(2 + k));
         check_eq("R7 streamed byte", got[k], regval(7'(2 + k)));
      end
      check_eq("R8 byte 8 zero", got[7], 0);
      check_eq("R8 byte 9 zero", got[8], 0);
      xbyte(8'h42, r);
      xbyte(8'h00, r);
      xbyte(8'h81, r);
      xbyte(8'h55, r);
      wclk(4);
      check_eq("R9 locked no read", rd_count, r0 + 7);
      check_eq("R9 locked no write", wr_count, w0);
      cs_hi();
      cs_lo();
      xbyte(8'h03, r);
      xbyte(8'h00, r);
      cs_hi();
      check_eq("R9 read after unlock", r, regval(7'h03));
      check_eq("R9 strobe after unlock", rd_count, r0 + 8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      t_reset();
      t_cs_high_ignored();
      t_write();
      t_read();
      t_back_to_back();
      t_abort();
      t_stream();
      report();
      $finish;
   end

endmodule